// File: doc/BRIEF.md
# Receive IQ Mismatch Coefficient Calculator

This block turns the accumulated statistics of a receive chain into the two small correction coefficients that a receive path uses to cancel IQ imbalance. It works on one chain at a time. For each chain it takes three 32-bit sums: the power seen on the I rail, the power seen on the Q rail, and the signed I·Q cross-correlation. It then produces a 7-bit phase-correction code and a 7-bit gain-correction code, both in two's complement. The two quotients come from one shared 32-step restoring divider. The phase quotient is computed first and the gain quotient second.

A single `start` pulse, accepted only while the block is idle, launches a run over chains `0 .. chain_cnt-1`. Each chain ends with a one-cycle `chain_done` pulse. The pulse carries the chain number on `chain_id`, and `chain_valid` shows whether coefficients were written. A chain whose denominators work out to zero reports `chain_valid = 0` and keeps its previous codes. Once every configured chain has reported, whatever the results were, `corr_en` goes high. It stays high until the next accepted start or a reset.

The controller has six states:
- **ST_IDLE**: waits for `start`. It moves to ST_LOAD, or to ST_FINAL when the count is zero.
- **ST_LOAD**: latches the chain's derived operands and checks the denominators. It moves to ST_REPORT when a denominator is zero, and otherwise starts the divider and moves to ST_DIV_PH.
- **ST_DIV_PH**: waits for the phase quotient, then restarts the divider and moves to ST_DIV_GN.
- **ST_DIV_GN**: waits for the gain quotient, then moves to ST_REPORT.
- **ST_REPORT**: writes the codes and pulses done. It moves back to ST_LOAD for the next chain, or to ST_FINAL after the last one.
- **ST_FINAL**: raises `corr_en` and returns to ST_IDLE.

Top module: `rxiq_coef_calc`

## Requirements
- R1: The correlation `xcorr` counts as negative only when its unsigned value is strictly above 0x80000000. A negative value is replaced by its two's-complement magnitude. The value 0x80000000 itself is taken as a positive magnitude.
- R2: The phase denominator is `((pwr_i>>1)+(pwr_q>>1))>>8` and the gain denominator is `pwr_q>>6`, both unsigned 32-bit.
- R3: If either denominator is zero, the chain reports `chain_done` with `chain_valid = 0`. Its `phase_coef` and `gain_coef` slots keep their earlier values. `chain_valid` is never high without `chain_done`.
- R4: The phase code is the unsigned quotient magnitude/phase-denominator, limited to 63. It is then negated when the correlation was not negative. It is output as a 7-bit two's-complement value in `phase_coef[7*c+6 : 7*c]`, so it never equals 0x40.
- R5: The gain code is `pwr_i` / gain-denominator minus 64, clamped to the range -63..+63 (quotient ≥127 gives 0x3F, quotient ≤1 gives 0x41). It is output as 7-bit two's complement in `gain_coef[7*c+6 : 7*c]`.
- R6: Chains are processed in ascending order 0, 1, 2 up to `chain_cnt-1`. Each chain produces exactly one single-cycle `chain_done`, with `chain_id` equal to the chain number.
- R7: `corr_en` is cleared when a run is accepted. It is set after the last configured chain has reported, whatever the per-chain validity was, and it is set directly when `chain_cnt = 0`. `busy` is low whenever `corr_en` is high.
- R8: A `start` that arrives while a run is in progress, including during the last chain's done cycle, is ignored.
- R9: A synchronous active-high `rst` clears all coefficients, `corr_en`, `chain_done` and `busy`, and aborts a run in progress.
- R10: `busy` is high from the cycle after an accepted `start` until the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, accepted in idle only |
| chain_cnt | input | CNT_W (2) | Number of chains to process (0..NCH) |
| pwr_i | input | NCH×32 | Per-chain I-rail power sum |
| pwr_q | input | NCH×32 | Per-chain Q-rail power sum |
| xcorr | input | NCH×32 | Per-chain I·Q correlation sum, two's complement |
| phase_coef | output | NCH×7 | Per-chain phase-correction code |
| gain_coef | output | NCH×7 | Per-chain gain-correction code |
| chain_done | output | 1 | One-cycle pulse when a chain finishes |
| chain_valid | output | 1 | With chain_done: coefficients were written |
| chain_id | output | CNT_W (2) | Chain number reported with chain_done |
| corr_en | output | 1 | Global correction enable after a complete run |
| busy | output | 1 | A run is in progress |

## Verification
Two events can fall in the same cycle: the report of the last chain and a fresh `start` request. Because the controller is still in ST_FINAL during that done cycle, the request must be dropped. The bench waits for the `chain_done` pulse carrying the final `chain_id` and drives `start` high during exactly that cycle. It then checks that no further done pulses appear, that `corr_en` rises and stays high, and that the coefficients equal those of the single run.

// File: rtl/rxiq_pkg.sv
package rxiq_pkg;
    localparam int STAT_W       = 32;
    localparam int COEF_W       = 7;
    localparam int PH_DEN_SHIFT = 8;
    localparam int GN_DEN_SHIFT = 6;
    localparam int GN_OFFSET    = 64;
    localparam int COEF_LIM     = 63;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_DIV_PH = 3'd2,
        ST_DIV_GN = 3'd3,
        ST_REPORT = 3'd4,
        ST_FINAL  = 3'd5
    } cal_state_t;
endpackage

// File: rtl/rxiq_seq_div.sv
module rxiq_seq_div #(
    parameter int W = 32
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q, quo_q, den_q;
    logic [CNT_W-1:0] left_q;
    logic             done_q;
    logic [W:0]       rem_sh, diff;

    always_comb begin
        rem_sh = {rem_q, quo_q[W-1]};
        diff   = rem_sh - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            left_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                rem_q  <= '0;
                quo_q  <= num;
                den_q  <= den;
                left_q <= CNT_W'(W);
            end else if (left_q != '0) begin
                if (!diff[W]) begin
                    rem_q <= diff[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= rem_sh[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                left_q <= left_q - CNT_W'(1);
                if (left_q == CNT_W'(1)) done_q <= 1'b1;
            end
        end
    end

    assign done = done_q;
    assign quo  = quo_q;
endmodule

// File: rtl/rxiq_stat_prep.sv
module rxiq_stat_prep
    import rxiq_pkg::*;
#(
    parameter int W = STAT_W
)(
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] p_q,
    input  logic [W-1:0] cor,
    output logic [W-1:0] mag,
    output logic         neg,
    output logic [W-1:0] ph_den,
    output logic [W-1:0] gn_den,
    output logic         den_zero
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        neg      = (cor > HALF);
        mag      = neg ? (~cor + W'(1)) : cor;
        ph_den   = ((p_i >> 1) + (p_q >> 1)) >> PH_DEN_SHIFT;
        gn_den   = p_q >> GN_DEN_SHIFT;
        den_zero = (ph_den == '0) || (gn_den == '0);
    end
endmodule

// File: rtl/rxiq_coef_quant.sv
module rxiq_coef_quant
    import rxiq_pkg::*;
#(
    parameter int W = STAT_W
)(
    input  logic [W-1:0]      q_ph,
    input  logic [W-1:0]      q_gn,
    input  logic              neg,
    output logic [COEF_W-1:0] ph_code,
    output logic [COEF_W-1:0] gn_code
);
    localparam logic [W-1:0]      PH_TOP  = W'(COEF_LIM);
    localparam logic [W-1:0]      GN_TOP  = W'(GN_OFFSET + COEF_LIM);
    localparam logic [W-1:0]      GN_BOT  = W'(GN_OFFSET - COEF_LIM);
    localparam logic [W-1:0]      GN_OFF  = W'(GN_OFFSET);
    localparam logic [COEF_W-1:0] POS_LIM = COEF_W'(COEF_LIM);
    localparam logic [COEF_W-1:0] NEG_LIM = COEF_W'((1 << COEF_W) - COEF_LIM);

    logic [COEF_W-1:0] ph_mag;

    always_comb begin
        ph_mag  = (q_ph >= PH_TOP) ? POS_LIM : COEF_W'(q_ph);
        ph_code = neg ? ph_mag : (COEF_W'(0) - ph_mag);
        if (q_gn >= GN_TOP)      gn_code = POS_LIM;
        else if (q_gn <= GN_BOT) gn_code = NEG_LIM;
        else                     gn_code = COEF_W'(q_gn - GN_OFF);
    end
endmodule

// File: rtl/rxiq_coef_calc.sv
module rxiq_coef_calc
    import rxiq_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int W     = STAT_W,
    parameter int CNT_W = $clog2(NCH + 1)
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [CNT_W-1:0]            chain_cnt,
    input  logic [NCH-1:0][W-1:0]       pwr_i,
    input  logic [NCH-1:0][W-1:0]       pwr_q,
    input  logic [NCH-1:0][W-1:0]       xcorr,
    output logic [NCH-1:0][COEF_W-1:0]  phase_coef,
    output logic [NCH-1:0][COEF_W-1:0]  gain_coef,
    output logic                        chain_done,
    output logic                        chain_valid,
    output logic [CNT_W-1:0]            chain_id,
    output logic                        corr_en,
    output logic                        busy
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

    cal_state_t        state_q, state_d;
    logic [CNT_W-1:0]  idx_q, cnt_q, cnt_eff;
    logic [IDX_W-1:0]  sel;
    logic [W-1:0]      mag_c, phden_c, gnden_c;
    logic              neg_c, den_zero;
    logic [W-1:0]      pi_r, gnden_r, q_ph_r, q_gn_r;
    logic              neg_r, valid_r;
    logic              div_go, div_done;
    logic [W-1:0]      div_num, div_den, div_q;
    logic [COEF_W-1:0] ph_code, gn_code;

    assign sel     = idx_q[IDX_W-1:0];
    assign cnt_eff = (chain_cnt > CNT_W'(NCH)) ? CNT_W'(NCH) : chain_cnt;
    assign busy    = (state_q != ST_IDLE);

    rxiq_stat_prep #(.W(W)) u_prep (
        .p_i(pwr_i[sel]), .p_q(pwr_q[sel]), .cor(xcorr[sel]),
        .mag(mag_c), .neg(neg_c), .ph_den(phden_c), .gn_den(gnden_c),
        .den_zero(den_zero)
    );

    // One divider: phase quotient first, gain quotient second.
    assign div_go  = ((state_q == ST_LOAD) && !den_zero) ||
                     ((state_q == ST_DIV_PH) && div_done);
    assign div_num = (state_q == ST_LOAD) ? mag_c   : pi_r;
    assign div_den = (state_q == ST_LOAD) ? phden_c : gnden_r;

    rxiq_seq_div #(.W(W)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .num(div_num), .den(div_den),
        .done(div_done), .quo(div_q)
    );

    rxiq_coef_quant #(.W(W)) u_quant (
        .q_ph(q_ph_r), .q_gn(q_gn_r), .neg(neg_r),
        .ph_code(ph_code), .gn_code(gn_code)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (cnt_eff == '0) ? ST_FINAL : ST_LOAD;
            ST_LOAD:   state_d = den_zero ? ST_REPORT : ST_DIV_PH;
            ST_DIV_PH: if (div_done) state_d = ST_DIV_GN;
            ST_DIV_GN: if (div_done) state_d = ST_REPORT;
            ST_REPORT: state_d = (idx_q == cnt_q - CNT_W'(1)) ? ST_FINAL : ST_LOAD;
            ST_FINAL:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_coef  <= '0;
            gain_coef   <= '0;
            chain_done  <= 1'b0;
            chain_valid <= 1'b0;
            chain_id    <= '0;
            corr_en     <= 1'b0;
            idx_q       <= '0;
            cnt_q       <= '0;
            pi_r        <= '0;
            gnden_r     <= '0;
            q_ph_r      <= '0;
            q_gn_r      <= '0;
            neg_r       <= 1'b0;
            valid_r     <= 1'b0;
        end else begin
            chain_done  <= 1'b0;
            chain_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    idx_q   <= '0;
                    cnt_q   <= cnt_eff;
                    corr_en <= 1'b0;
                end
                ST_LOAD: begin
                    pi_r    <= pwr_i[sel];
                    gnden_r <= gnden_c;
                    neg_r   <= neg_c;
                    valid_r <= 1'b0;
                end
                ST_DIV_PH: if (div_done) q_ph_r <= div_q;
                ST_DIV_GN: if (div_done) begin
                    q_gn_r  <= div_q;
                    valid_r <= 1'b1;
                end
                ST_REPORT: begin
                    chain_done  <= 1'b1;
                    chain_valid <= valid_r;
                    chain_id    <= idx_q;
                    if (valid_r) begin
                        phase_coef[sel] <= ph_code;
                        gain_coef[sel]  <= gn_code;
                    end
                    idx_q <= idx_q + CNT_W'(1);
                end
                ST_FINAL: corr_en <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxiq_coef_chk.sv
module rxiq_coef_chk
    import rxiq_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int CNT_W = 2
)(
    input logic                       clk,
    input logic                       rst,
    input logic                       start,
    input logic                       chain_done,
    input logic                       chain_valid,
    input logic [CNT_W-1:0]           chain_id,
    input logic                       corr_en,
    input logic                       busy,
    input logic [NCH-1:0][COEF_W-1:0] phase_coef,
    input logic [NCH-1:0][COEF_W-1:0] gain_coef
);
    localparam logic [COEF_W-1:0] MOST_NEG = {1'b1, {(COEF_W-1){1'b0}}};

    AST_VALID_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        chain_valid |-> chain_done); // R3
    AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && (!$stable(phase_coef) || !$stable(gain_coef))) |-> (chain_done && chain_valid)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        chain_done |=> !chain_done); // R6
    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        chain_done |-> (chain_id < CNT_W'(NCH))); // R6
    AST_EN_FALL_ON_START: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $fell(corr_en)) |-> $past(start)); // R7
    AST_EN_IDLE: assert property (@(posedge clk) disable iff (rst)
        corr_en |-> !busy); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!corr_en && !chain_done && !busy && phase_coef == '0 && gain_coef == '0)); // R9

    for (genvar c = 0; c < NCH; c++) begin : g_lim
        AST_PHASE_NO_MIN: assert property (@(posedge clk) disable iff (rst)
            phase_coef[c] != MOST_NEG); // R4
        AST_GAIN_NO_MIN: assert property (@(posedge clk) disable iff (rst)
            gain_coef[c] != MOST_NEG); // R5
    end
endmodule

bind rxiq_coef_calc rxiq_coef_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .chain_done(chain_done),
    .chain_valid(chain_valid), .chain_id(chain_id), .corr_en(corr_en),
    .busy(busy), .phase_coef(phase_coef), .gain_coef(gain_coef)
);

// File: tb/rxiq_coef_calc_test.sv
module rxiq_coef_calc_test;
    localparam int NCH = 3;

    typedef struct packed {
        logic [31:0] pi;
        logic [31:0] pq;
        logic [31:0] cr;
        logic        v;
        logic [6:0]  ph;
        logic [6:0]  gn;
    } vec_t;

    // Single-chain vectors on chain 0; expected codes are computed by hand from R1..R5.
    localparam vec_t VECS [8] = '{
        '{32'h0001_0000, 32'h0001_0000, 32'h0000_1000, 1'b1, 7'h70, 7'h00}, // R2 R4: 16 -> -16
        '{32'h0001_8000, 32'h0000_8000, 32'hFFFF_F000, 1'b1, 7'h10, 7'h3F}, // R1 neg, R5 top clamp
        '{32'h0000_4000, 32'h0004_0000, 32'h0010_0000, 1'b1, 7'h41, 7'h44}, // R4 clamp, R5 -60
        '{32'h0000_1000, 32'h0010_0000, 32'h8000_0000, 1'b1, 7'h41, 7'h41}, // R1 boundary, R5 low clamp
        '{32'h0001_0000, 32'h0001_0000, 32'h8000_0001, 1'b1, 7'h3F, 7'h00}, // R1 neg, R4 +63
        '{32'h0001_F800, 32'h0001_0000, 32'h0000_0000, 1'b1, 7'h00, 7'h3E}, // R5 62
        '{32'h1000_0000, 32'h0000_003F, 32'h0000_1234, 1'b0, 7'h00, 7'h3E}, // R2 R3 gain den zero
        '{32'h0000_00FF, 32'h0000_0040, 32'h0000_1234, 1'b0, 7'h00, 7'h3E}  // R2 R3 phase den zero
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] chain_cnt = '0;
    logic [NCH-1:0][31:0] pwr_i = '0, pwr_q = '0, xcorr = '0;
    logic [NCH-1:0][6:0] phase_coef, gain_coef;
    logic chain_done, chain_valid, corr_en, busy;
    logic [1:0] chain_id;

    rxiq_coef_calc #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .start(start), .chain_cnt(chain_cnt),
        .pwr_i(pwr_i), .pwr_q(pwr_q), .xcorr(xcorr),
        .phase_coef(phase_coef), .gain_coef(gain_coef),
        .chain_done(chain_done), .chain_valid(chain_valid), .chain_id(chain_id),
        .corr_en(corr_en), .busy(busy)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int done_n = 0;
    logic [1:0] done_id [64];
    logic       done_v  [64];

    always @(negedge clk) begin
        if (!rst && chain_done) begin
            done_id[done_n % 64] = chain_id;
            done_v[done_n % 64]  = chain_valid;
            done_n = done_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input logic [1:0] n);
        @(negedge clk);
        chain_cnt = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(corr_en == 1'b0, "R9 corr_en after reset", 32'(corr_en), 0);
        check(busy == 1'b0, "R10 busy after reset", 32'(busy), 0);
        check(phase_coef == '0 && gain_coef == '0, "R9 coefs after reset", 32'(phase_coef), 0);

        for (int v = 0; v < 8; v++) begin
            pwr_i[0] = VECS[v].pi;
            pwr_q[0] = VECS[v].pq;
            xcorr[0] = VECS[v].cr;
            base = done_n;
            run(2'd1);
            check(done_n - base == 1, "R6 one done per chain", 32'(done_n - base), 1);
            check(done_id[base % 64] == 2'd0, "R6 chain id", 32'(done_id[base % 64]), 0);
            check(done_v[base % 64] == VECS[v].v, "R3 R2 valid flag", 32'(done_v[base % 64]), 32'(VECS[v].v));
            check(phase_coef[0] == VECS[v].ph, "R1 R4 phase code", 32'(phase_coef[0]), 32'(VECS[v].ph));
            check(gain_coef[0] == VECS[v].gn, "R5 gain code", 32'(gain_coef[0]), 32'(VECS[v].gn));
            check(corr_en == 1'b1, "R7 enable after run", 32'(corr_en), 1);
        end

        // R9: reset clears the nonzero gain code left by the table
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(gain_coef == '0 && corr_en == 1'b0, "R9 clear after use", 32'(gain_coef), 0);

        // Three chains, middle one invalid; start repeated in the last done cycle (R8)
        pwr_i[0] = 32'h0000_4000; pwr_q[0] = 32'h0004_0000; xcorr[0] = 32'h0010_0000;
        pwr_i[1] = 32'h0000_00FF; pwr_q[1] = 32'h0000_0040; xcorr[1] = 32'h0000_1234;
        pwr_i[2] = 32'h0001_0000; pwr_q[2] = 32'h0001_0000; xcorr[2] = 32'h0000_1000;
        base = done_n;
        @(negedge clk);
        chain_cnt = 2'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", 32'(busy), 1);
        check(corr_en == 1'b0, "R7 enable cleared at start", 32'(corr_en), 0);
        for (int k = 0; k < 3000 && !(chain_done && chain_id == 2'd2); k++) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        check(done_n - base == 3, "R8 R6 done count", 32'(done_n - base), 3);
        check(done_id[base % 64] == 2'd0 && done_id[(base + 1) % 64] == 2'd1 && done_id[(base + 2) % 64] == 2'd2,
              "R6 chain order", {done_id[(base + 2) % 64], done_id[(base + 1) % 64], done_id[base % 64]}, 32'h24);
        check({done_v[(base + 2) % 64], done_v[(base + 1) % 64], done_v[base % 64]} == 3'b101,
              "R3 per-chain valid", 32'({done_v[(base + 2) % 64], done_v[(base + 1) % 64], done_v[base % 64]}), 32'h5);
        check(phase_coef == {7'h70, 7'h00, 7'h41}, "R4 three phase codes", 32'(phase_coef), 32'({7'h70, 7'h00, 7'h41}));
        check(gain_coef == {7'h00, 7'h00, 7'h44}, "R5 three gain codes", 32'(gain_coef), 32'({7'h00, 7'h00, 7'h44}));
        check(corr_en == 1'b1 && busy == 1'b0, "R7 enable despite invalid chain", 32'({corr_en, busy}), 2);

        // R8: start pulsed mid-run with a larger count
        base = done_n;
        @(negedge clk);
        chain_cnt = 2'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chain_cnt = 2'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (200) @(negedge clk);
        check(done_n - base == 2, "R8 start while busy ignored", 32'(done_n - base), 2);

        // R9: reset in the middle of a run
        base = done_n;
        @(negedge clk);
        chain_cnt = 2'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && corr_en == 1'b0, "R9 run aborted", 32'({busy, corr_en}), 0);
        check(phase_coef == '0 && gain_coef == '0, "R9 coefs cleared mid-run", 32'(phase_coef), 0);
        repeat (300) @(negedge clk);
        check(done_n == base, "R9 no done after abort", 32'(done_n - base), 0);

        // R7: zero chains raises the enable with no chain report
        run(2'd0);
        check(corr_en == 1'b1, "R7 enable with zero chains", 32'(corr_en), 1);
        check(done_n == base, "R6 no done with zero chains", 32'(done_n - base), 0);
        check(phase_coef == '0 && gain_coef == '0, "R3 coefs untouched with zero chains", 32'(phase_coef), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule